// File: doc/BRIEF.md
# Looping Microcode Cycle Sequencer

This block supplies the step number (0 to 3) that a microcoded instruction decoder uses to pick the microinstruction row for the current clock. Each row carries a two-bit sequencing command. The sequencer reads that command and returns the step for the next clock. The command can end the instruction, advance by one step, or loop in place until a "register list exhausted" flag from a priority encoder goes high. The loops let a block transfer repeat its transfer step as often as it needs, so its length is not fixed.

Two status outputs go back to the core. One marks step 0, where a new instruction begins. The other aborts an instruction whose condition check failed. That instruction then lasts one clock and its own command is ignored. The block has an asynchronous active-low reset, and the release of that reset is synchronised inside the block.

Top module: `ucode_cycle_seq`

## Requirements
- R1: While `rst_n` is low, `cycle` is 0 and `new_inst` is 1.
- R2: Command code 2'b00 (end) makes the next `cycle` 0.
- R3: Command code 2'b01 (advance) makes the next `cycle` the current one plus 1, modulo 4, so 3 wraps to 0.
- R4: Command code 2'b10 (loop on 2) makes the next `cycle` 2 while `list_done` is 0 and 3 when `list_done` is 1.
- R5: Command code 2'b11 (loop on 1) makes the next `cycle` 1 while `list_done` is 0 and 0 when `list_done` is 1.
- R6: `new_inst` is 1 exactly when `cycle` is 0.
- R7: When `skip` is 1 and `cycle` is 0, `abort_inst` is 1 and the next `cycle` is 0, whatever the command and `list_done` are.
- R8: When `cycle` is not 0, `skip` has no effect: `abort_inst` stays 0 and the next `cycle` follows the command.
- R9: After `rst_n` rises, `cycle` stays 0 for SYNC_STAGES rising clock edges. It follows the command from the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `cycle` updates on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_cmd | input | 2 | Sequencing command from the current microinstruction |
| list_done | input | 1 | High when the register list has no entries left |
| skip | input | 1 | High when the current instruction's condition failed |
| cycle | output | 2 | Current step number |
| new_inst | output | 1 | High on step 0 |
| abort_inst | output | 1 | High when the instruction in step 0 is being skipped |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. The two clocks during which `cycle` is held at 0 after reset release can therefore be counted exactly. With a two-bit step there are only four states, so random commands soon cover every command in every step, including the advance that wraps from 3 to 0 and a skip raised outside step 0. Directed runs add a three-step load, a five-clock hold on step 2 before step 3, a loop on step 1 that exits to step 0, and aborts under the loop commands.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  localparam int CYC_W = 2;
  localparam int CMD_W = 2;
  typedef logic [CYC_W-1:0] cyc_t;
  typedef enum logic [CMD_W-1:0] {
    CMD_END  = 2'b00,
    CMD_NEXT = 2'b01,
    CMD_IF23 = 2'b10,
    CMD_IF1E = 2'b11
  } seq_cmd_e;
endpackage

// File: rtl/ucseq_rst_sync.sv
module ucseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/ucseq_next.sv
module ucseq_next
  import ucseq_pkg::*;
(
  input  cyc_t             cur,
  input  logic [CMD_W-1:0] cmd,
  input  logic             done,
  input  logic             skip,
  output cyc_t             nxt,
  output logic             abort
);
  cyc_t cmd_nxt;

  always_comb begin
    unique case (seq_cmd_e'(cmd))
      CMD_END:  cmd_nxt = '0;
      CMD_NEXT: cmd_nxt = {cur[1] ^ cur[0], ~cur[0]};
      CMD_IF23: cmd_nxt = {1'b1, done};
      CMD_IF1E: cmd_nxt = {1'b0, ~done};
      default:  cmd_nxt = '0;
    endcase
  end

  always_comb begin
    abort = skip && (cur == '0);
    nxt   = abort ? cyc_t'('0) : cmd_nxt;
  end
endmodule

// File: rtl/ucseq_cycle_reg.sv
module ucseq_cycle_reg
  import ucseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  cyc_t d,
  output cyc_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/ucode_cycle_seq.sv
module ucode_cycle_seq
  import ucseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] seq_cmd,
  input  logic       list_done,
  input  logic       skip,
  output logic [1:0] cycle,
  output logic       new_inst,
  output logic       abort_inst
);
  logic rst_sync_n;
  cyc_t cyc_q;
  cyc_t cyc_d;
  logic abort_w;

  ucseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ucseq_next u_next (
    .cur(cyc_q), .cmd(seq_cmd), .done(list_done), .skip(skip),
    .nxt(cyc_d), .abort(abort_w)
  );

  ucseq_cycle_reg u_reg (
    .clk(clk), .rst_n(rst_sync_n), .en(1'b1), .d(cyc_d), .q(cyc_q)
  );

  assign cycle      = cyc_q;
  assign new_inst   = (cyc_q == '0);
  assign abort_inst = abort_w;
endmodule

// File: rtl/ucode_cycle_seq_chk.sv
module ucode_cycle_seq_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [1:0] seq_cmd,
  input logic       list_done,
  input logic       skip,
  input logic [1:0] cycle,
  input logic       new_inst,
  input logic       abort_inst
);
  p_end_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_cmd == 2'b00) |=> (cycle == 2'd0));

  p_next_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_cmd == 2'b01 && !abort_inst) |=> (cycle == 2'($past(cycle) + 2'd1)));

  p_if23_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_cmd == 2'b10 && !abort_inst) |=> (cycle == {1'b1, $past(list_done)}));

  p_if1e_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_cmd == 2'b11 && !abort_inst) |=> (cycle == {1'b0, ~$past(list_done)}));

  p_abort_end_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort_inst |=> new_inst);

  p_abort_only_c0_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    abort_inst |-> (new_inst && skip));
endmodule

bind ucode_cycle_seq ucode_cycle_seq_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .seq_cmd(seq_cmd), .list_done(list_done),
  .skip(skip), .cycle(cycle), .new_inst(new_inst), .abort_inst(abort_inst)
);

// File: tb/ucode_cycle_seq_tb.sv
module ucode_cycle_seq_tb;
  localparam int SYNC = 2;
  logic       clk;
  logic       rst_n;
  logic [1:0] seq_cmd;
  logic       list_done;
  logic       skip;
  logic [1:0] cycle;
  logic       new_inst;
  logic       abort_inst;
  int checks;
  int failures;
  logic [1:0] exp_cyc;

  ucode_cycle_seq #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .seq_cmd(seq_cmd), .list_done(list_done),
    .skip(skip), .cycle(cycle), .new_inst(new_inst), .abort_inst(abort_inst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [1:0] model_next(logic [1:0] cur, logic [1:0] cmd,
                                            logic done, logic skp);
    if (skp && cur == 2'd0) return 2'd0;
    case (cmd)
      2'b00:   return 2'd0;
      2'b01:   return 2'(cur + 2'd1);
      2'b10:   return done ? 2'd3 : 2'd2;
      default: return done ? 2'd0 : 2'd1;
    endcase
  endfunction

  function automatic string cmd_req(logic [1:0] cmd);
    case (cmd)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic [1:0] cmd, logic done, logic skp);
    string tag;
    @(negedge clk);
    seq_cmd = cmd; list_done = done; skip = skp;
    #1;
    check("R6 new_inst", int'(new_inst), int'(exp_cyc == 2'd0));
    tag = (exp_cyc == 2'd0) ? "R7 abort" : "R8 abort";
    check(tag, int'(abort_inst), int'(skp && exp_cyc == 2'd0));
    if (skp && exp_cyc == 2'd0) tag = "R7 cycle";
    else if (skp)               tag = {"R8 ", cmd_req(cmd)};
    else                        tag = cmd_req(cmd);
    exp_cyc = model_next(exp_cyc, cmd, done, skp);
    @(posedge clk); #1;
    check(tag, int'(cycle), int'(exp_cyc));
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed_dummy;
    checks = 0; failures = 0;
    seed_dummy = $urandom(32'h5EC1);
    rst_n = 1'b0; seq_cmd = 2'b01; list_done = 1'b0; skip = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R1 cycle", int'(cycle), 0);
    check("R1 new_inst", int'(new_inst), 1);
    // R9: release with advance held
    @(negedge clk); rst_n = 1'b1;
    repeat (SYNC) @(posedge clk);
    #1; check("R9 held", int'(cycle), 0);
    @(posedge clk); #1; check("R9 first step", int'(cycle), 1);
    exp_cyc = 2'd1;
    step(2'b00, 1'b0, 1'b0);
    // load: advance, advance, end (R3, R2)
    step(2'b01, 1'b0, 1'b0);
    step(2'b01, 1'b0, 1'b0);
    step(2'b00, 1'b0, 1'b0);
    // block transfer looping on 2 for 5 clocks (R4)
    step(2'b01, 1'b0, 1'b0);
    step(2'b01, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(2'b10, 1'b0, 1'b0);
    step(2'b10, 1'b1, 1'b0);
    check("R4 reached 3", int'(cycle), 3);
    // wrap 3 -> 0 (R3)
    step(2'b01, 1'b0, 1'b0);
    check("R3 wrap", int'(cycle), 0);
    // loop on 1 then exit (R5)
    step(2'b01, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(2'b11, 1'b0, 1'b0);
    step(2'b11, 1'b1, 1'b0);
    // abort under several commands (R7)
    step(2'b01, 1'b0, 1'b1);
    step(2'b10, 1'b1, 1'b1);
    step(2'b11, 1'b0, 1'b1);
    // skip outside step 0 is ignored (R8)
    step(2'b01, 1'b0, 1'b0);
    step(2'b01, 1'b0, 1'b1);
    step(2'b10, 1'b1, 1'b1);
    step(2'b00, 1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 400; i++)
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule